// File: doc/BRIEF.md
# Serial GPIO Edge Event Detector

This block sits behind a serial pin-expansion shift engine. Once per frame that engine refreshes a 64-bit vector of input pin levels and pulses a valid strobe. The detector compares each valid frame with the one before it and looks for transitions. Every pin can be set to react to a low-to-high change, a high-to-low change, either change, or nothing.

Detected transitions latch into sticky status bits, which are grouped into one byte per bank of eight pins. Software clears these bits by writing ones. The OR of all status bits drives a single registered interrupt line.

Pin settings live in one 16-bit word per bank, and a byte-wide register port reaches them. The port writes and reads these words a byte at a time. The same port reads and clears the status bytes.

Top module: `pin_edge_event_unit`

## Requirements
- R1: After reset, every configuration byte and every status byte reads 0 and `irq_o` is 0.
- R2: Bank b's configuration word sits at byte offset 0x10+2b (bits 7:0) and 0x11+2b (bits 15:8). Pin n of the bank uses word bits 2n+1:2n. A written byte reads back unchanged.
- R3: Field bit 0 enables low-to-high detection. With field 01, a pin that was 0 in the previous valid frame and is 1 in the current one sets its status bit. A high-to-low change on that pin sets nothing.
- R4: Field bit 1 enables high-to-low detection. With field 10, only a 1-to-0 change between valid frames sets the status bit.
- R5: Field 11 reacts to either change. Field 00 never sets the status bit.
- R6: Frames without `sample_vld` are ignored. The first valid frame after reset, or after `detect_en` rises again, only loads the previous-frame register and raises no event. While `detect_en` is 0 no event is raised.
- R7: Status byte of bank b is at offset 0x20+b, and bit j reports pin 8b+j. A set bit stays set with no further transitions.
- R8: Writing a status byte clears each bit written as 1. Bits written as 0 keep their value.
- R9: When a new event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R10: `irq_o` equals the OR of all status bits as they were one clock earlier.
- R11: Setting a pin's field to 00 leaves an already-set status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| detect_en | input | 1 | Detection enable; low drops the previous-frame history |
| sample_vld | input | 1 | Strobe marking a fresh input frame |
| sample_data | input | 64 | Input pin levels, pin 8b+j at bit 8b+j |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 6 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational; 0 for unmapped offsets |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The hardest case is a clearing write and a fresh transition landing on one status bit in the same clock. To reach it, the bench drives the status write and a valid frame in the same cycle, with the same pin toggling in that frame.

A second hard case is the re-arm after `detect_en` is cycled. The bench leaves a stale frame in the history register, disables detection, then re-enables it with a frame that would count as an edge against that stale value. No status bit may be raised by that frame.

// File: rtl/sgpe_pkg.sv
package sgpe_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned FIELD_W = 2;
  localparam int unsigned CFG_W = LANE_W * FIELD_W;

  // Per-lane transition hits for one bank: field bit 0 = low-to-high, bit 1 = high-to-low.
  function automatic logic [LANE_W-1:0] lane_hits(input logic [CFG_W-1:0] cfg,
                                                   input logic [LANE_W-1:0] prev,
                                                   input logic [LANE_W-1:0] cur);
    logic [LANE_W-1:0] res;
    for (int k = 0; k < LANE_W; k++) begin
      res[k] = (cfg[FIELD_W*k]   & ~prev[k] &  cur[k]) |
               (cfg[FIELD_W*k+1] &  prev[k] & ~cur[k]);
    end
    return res;
  endfunction
endpackage

// File: rtl/sgpe_cfg_regs.sv
module sgpe_cfg_regs
  import sgpe_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CFG_BASE  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LANE_W-1:0]          wdata,
  output logic [NUM_BANKS*CFG_W-1:0] cfg_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [LANE_W-1:0] lo_q, hi_q;
    logic lo_sel, hi_sel;
    assign lo_sel = wr_en && (addr == ADDR_W'(CFG_BASE + 2*b));
    assign hi_sel = wr_en && (addr == ADDR_W'(CFG_BASE + 2*b + 1));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_sel) lo_q <= wdata;
        if (hi_sel) hi_q <= wdata;
      end
    end
    assign cfg_o[b*CFG_W +: CFG_W] = {hi_q, lo_q};
  end
endmodule

// File: rtl/sgpe_edge_detect.sv
module sgpe_edge_detect
  import sgpe_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned NPINS    = NUM_BANKS * LANE_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       det_en,
  input  logic                       smp_vld,
  input  logic [NPINS-1:0]           smp_data,
  input  logic [NUM_BANKS*CFG_W-1:0] cfg,
  output logic [NPINS-1:0]           hit_o,
  output logic                       primed_o
);
  logic [NPINS-1:0] prev_q;
  logic             primed_q;
  logic             compare_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (!det_en) begin
      primed_q <= 1'b0;
    end else if (smp_vld) begin
      prev_q   <= smp_data;
      primed_q <= 1'b1;
    end
  end

  assign compare_now = det_en && smp_vld && primed_q;
  assign primed_o    = primed_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign hit_o[b*LANE_W +: LANE_W] = compare_now ?
      lane_hits(cfg[b*CFG_W +: CFG_W], prev_q[b*LANE_W +: LANE_W], smp_data[b*LANE_W +: LANE_W])
      : '0;
  end
endmodule

// File: rtl/sgpe_status.sv
module sgpe_status
  import sgpe_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned STS_BASE  = 32,
  localparam int unsigned NPINS    = NUM_BANKS * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  input  logic [NPINS-1:0]  hit,
  output logic [NPINS-1:0]  status_o,
  output logic [NPINS-1:0]  clr_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sts_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
    assign clr_o[b*LANE_W +: LANE_W] =
      (wr_en && (addr == ADDR_W'(STS_BASE + b))) ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      irq_o <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_o) | hit;
      irq_o <= |sts_q;
    end
  end

  assign status_o = sts_q;
endmodule

// File: rtl/pin_edge_event_unit.sv
module pin_edge_event_unit
  import sgpe_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CFG_BASE  = 16,
  parameter int unsigned STS_BASE  = 32,
  localparam int unsigned NPINS    = NUM_BANKS * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              detect_en,
  input  logic              sample_vld,
  input  logic [NPINS-1:0]  sample_data,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [LANE_W-1:0] reg_wdata,
  output logic [LANE_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NUM_BANKS*CFG_W-1:0] cfg_vec;
  logic [NPINS-1:0]           hit_vec;
  logic [NPINS-1:0]           clr_vec;
  logic [NPINS-1:0]           status_vec;
  logic                       primed;

  sgpe_cfg_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cfg_o(cfg_vec)
  );

  sgpe_edge_detect #(.NUM_BANKS(NUM_BANKS)) u_det (
    .clk(clk), .rst_n(rst_n), .det_en(detect_en), .smp_vld(sample_vld),
    .smp_data(sample_data), .cfg(cfg_vec), .hit_o(hit_vec), .primed_o(primed)
  );

  sgpe_status #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .STS_BASE(STS_BASE)) u_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit_vec), .status_o(status_vec), .clr_o(clr_vec), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr == ADDR_W'(CFG_BASE + 2*b))
        reg_rdata = cfg_vec[b*CFG_W +: LANE_W];
      if (reg_addr == ADDR_W'(CFG_BASE + 2*b + 1))
        reg_rdata = cfg_vec[b*CFG_W + LANE_W +: LANE_W];
      if (reg_addr == ADDR_W'(STS_BASE + b))
        reg_rdata = status_vec[b*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/sgpe_checker.sv
module sgpe_checker #(
  parameter int unsigned NPINS = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] clr,
  input logic [NPINS-1:0] status,
  input logic             primed,
  input logic             irq
);
  // R10
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == (|$past(status))));

  // R9
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status & $past(hit)) == $past(hit)));

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((status & $past(clr) & ~$past(hit)) == '0));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0 && clr == '0) |=> $stable(status));

  // R6
  unprimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> (hit == '0));
endmodule

bind pin_edge_event_unit sgpe_checker #(.NPINS(NPINS)) u_sgpe_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit_vec), .clr(clr_vec),
  .status(status_vec), .primed(primed), .irq(irq_o)
);

// File: tb/test_pin_edge_event_unit.sv
`timescale 1ns/10ps
module test_pin_edge_event_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        detect_en = 1'b0;
  logic        sample_vld = 1'b0;
  logic [63:0] sample_data = '0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  int issued = 0;
  int retired = 0;
  bit finished = 0;

  typedef struct {
    bit          is_irq;
    logic [5:0]  addr;
    logic [7:0]  exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pin_edge_event_unit i_pin_edge_event_unit (
    .clk(clk), .rst_n(rst_n), .detect_en(detect_en), .sample_vld(sample_vld),
    .sample_data(sample_data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      item_t it;
      logic [7:0] act;
      wait (sb_q.size() != 0);
      it = sb_q.pop_front();
      #0.1;
      if (it.is_irq) begin
        act = {7'd0, irq_o};
      end else begin
        reg_addr = it.addr;
        #0.1;
        act = reg_rdata;
      end
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
      retired++;
    end
  end

  task automatic chk(input logic [5:0] a, input logic [7:0] e, input string tag);
    sb_q.push_back('{1'b0, a, e, tag});
    issued++;
    wait (retired == issued);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_q.push_back('{1'b1, 6'd0, {7'd0, e}, tag});
    issued++;
    wait (retired == issued);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic smp(input logic [63:0] d);
    @(negedge clk);
    sample_vld = 1'b1; sample_data = d;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [63:0] D45 = 64'h0000_2000_0000_0000;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1
    chk_irq(1'b0, "R1 irq after reset");
    chk(6'h20, 8'h00, "R1 status bank0 after reset");
    chk(6'h10, 8'h00, "R1 cfg bank0 lo after reset");
    chk(6'h1F, 8'h00, "R1 cfg bank7 hi after reset");

    detect_en = 1'b1;
    // R2: pin0=01, pin1=10, pin2=11, pin3=00
    wr(6'h10, 8'h39);
    chk(6'h10, 8'h39, "R2 cfg bank0 lo readback");
    // bank5 pin5 and pin7 = 01
    wr(6'h1B, 8'h44);
    chk(6'h1B, 8'h44, "R2 cfg bank5 hi readback");

    // R6: first valid frame only primes
    smp(64'h0F);
    chk(6'h20, 8'h00, "R6 first frame no event");

    // R4 R5: falling on pins 0..3 -> pin1 and pin2 only
    smp(64'h00);
    chk(6'h20, 8'h06, "R4 R5 falling edges");
    wr(6'h20, 8'h06);
    chk(6'h20, 8'h00, "R8 clear both");

    // R3 R5: rising -> pin0 and pin2
    smp(64'h0F);
    chk(6'h20, 8'h05, "R3 R5 rising edges");
    chk_irq(1'b0, "R10 irq lags status");
    idle(1);
    chk_irq(1'b1, "R10 irq raised");

    // R6: invalid frame ignored, then same-level valid frame -> no change
    @(negedge clk); sample_vld = 1'b0; sample_data = 64'h00;
    smp(64'h0F);
    chk(6'h20, 8'h05, "R6 R7 invalid frame ignored, sticky");

    // R8 partial clear and zero write
    wr(6'h20, 8'h01);
    chk(6'h20, 8'h04, "R8 clear one bit");
    wr(6'h20, 8'h00);
    chk(6'h20, 8'h04, "R8 zero write no effect");

    // R7 index mapping: pin 45 = bank5 bit5
    smp(D45 | 64'h0F);
    chk(6'h25, 8'h20, "R7 bank5 bit5 set");
    chk(6'h24, 8'h00, "R7 bank4 untouched");

    // R11
    wr(6'h1B, 8'h00);
    chk(6'h25, 8'h20, "R11 disable field keeps status");

    // R9: clear and new event on pin2 in same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'h20; reg_wdata = 8'h04;
    sample_vld = 1'b1; sample_data = D45 | 64'h0B;
    @(negedge clk);
    reg_wr = 1'b0; sample_vld = 1'b0;
    chk(6'h20, 8'h04, "R9 event beats clear");

    // R10 fall of irq after clearing all
    wr(6'h20, 8'hFF);
    wr(6'h25, 8'hFF);
    chk(6'h25, 8'h00, "R8 clear bank5");
    chk_irq(1'b1, "R10 irq still high one cycle");
    idle(1);
    chk_irq(1'b0, "R10 irq low");

    // R6: re-arm after enable cycle
    @(negedge clk); detect_en = 1'b0;
    smp(64'h00);
    chk(6'h20, 8'h00, "R6 disabled no event");
    @(negedge clk); detect_en = 1'b1;
    smp(D45 | 64'h0F);
    chk(6'h20, 8'h00, "R6 first frame after enable no event");
    smp(D45 | 64'h0B);
    chk(6'h20, 8'h04, "R5 R6 re-armed detection");

    idle(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule